// File: doc/BRIEF.md
# Guarded Low-Power Mode Controller

This block owns the power-control byte of a small processor. It decides when the core may drop into idle, where the processor clock is gated and the peripherals and oscillator keep running, or into power-down, where the oscillator is stopped. To make an accidental entry from a stray write unlikely, neither mode can be reached with one write. Software must first write an arm bit for the mode on its own. The very next write to the register must then set that mode's start bit on its own. A low-power mode can only be entered while the external permission pin `mode_lock_i` is low.

The command bits never hold a value. They always read back as zero. The other four bits of the byte are plain read/write storage. While power-down is active, the block also drives hold requests that park the clock output, the address latch strobe and the program fetch strobe low.

The control is a five-state machine:
- RUN is the normal state.
- IDLE_ARMED and PD_ARMED record a valid arm write.
- IDLE and PDOWN are the two modes.

Transitions:
- arm: RUN or an armed state goes to an armed state on a clean arm write.
- disarm: an armed state goes back to RUN on any other write, or when `mode_lock_i` is high.
- start: IDLE_ARMED goes to IDLE, or PD_ARMED goes to PDOWN, on a clean start write.
- wake: IDLE goes to RUN on a pending interrupt.
- reset: any state goes to RUN.

Top module: `pwr_mode_guard`

## Requirements
- R1: While `mode_lock_i` is high, no write causes an entry into either mode, and an armed state returns to RUN at the next clock edge.
- R2: Idle uses arm bit 0 and start bit 5. Power-down uses arm bit 1 and start bit 6. A write with bit 0 set and bit 5 clear, directly followed by a write with bit 5 set and bit 0 clear, sets `idle_o` at the clock edge that accepts the second write. The same sequence using bits 1 and 6 sets `pdown_o`.
- R3: A start write with no arm write directly before it causes no entry. This includes the reversed order, start then arm.
- R4: A single write that sets both the arm bit and the start bit of one mode neither enters nor arms that mode. A write that sets both arm bits (bits 0 and 1) arms nothing.
- R5: Any write between the arm write and the start write cancels the arm, unless that write is itself a clean arm write, which arms again.
- R6: `rd_data_o` bits 0, 1, 5 and 6 always read 0. Bits 2, 3, 4 and 7 return the last value written to them.
- R7: In IDLE, a high `irq_pend_i` clears `idle_o` at the next clock edge. Writes made in IDLE or PDOWN change neither the stored bits nor the state.
- R8: PDOWN persists regardless of interrupts and writes until reset. `clkout_hold_o`, `ale_hold_o` and `psen_hold_o` are high exactly when `pdown_o` is high.
- R9: A high `rst_i` clears `idle_o` and `pdown_o` at the next clock edge. The stored bits clear only once `rst_i` has been held high across `RST_MC` (default 2) `mc_stb_i` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (oscillator-derived) |
| rst_i | input | 1 | Reset request, active high, sampled on the clock |
| mc_stb_i | input | 1 | One-clock strobe per machine cycle |
| mode_lock_i | input | 1 | High forbids low-power entry |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Read value of the control byte |
| idle_o | output | 1 | Idle mode active, processor clock gated |
| pdown_o | output | 1 | Power-down active, oscillator stop |
| clkout_hold_o | output | 1 | Hold clock output low |
| ale_hold_o | output | 1 | Hold address latch strobe low |
| psen_hold_o | output | 1 | Hold program fetch strobe low |

## Verification
The hardest situation to reach from the ports is an arm that is still valid when the start write arrives, with nothing in between. Random writes almost always disarm first. The random stimulus therefore draws most of its write values from the clean arm, clean start and combined codes, which makes arm-then-start pairs, reversed pairs and interrupted pairs frequent. Directed sequences cover the other cases: an arm write followed by a lock-high start, re-arming, and a short reset compared with a full-length reset while the block is in a mode.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    typedef enum logic [2:0] {
        PM_RUN        = 3'd0,
        PM_IDLE_ARMED = 3'd1,
        PM_PD_ARMED   = 3'd2,
        PM_IDLE       = 3'd3,
        PM_PDOWN      = 3'd4
    } pm_state_t;

    typedef struct packed {
        logic arm_idle;
        logic go_idle;
        logic arm_pd;
        logic go_pd;
    } pm_cmd_t;

endpackage

// File: rtl/pmg_cmd_decode.sv
module pmg_cmd_decode #(
    parameter int DW        = 8,
    parameter int IDLE_ARM  = 0,
    parameter int IDLE_GO   = 5,
    parameter int PD_ARM    = 1,
    parameter int PD_GO     = 6
) (
    input  logic [DW-1:0]    wr_data_i,
    output pmg_pkg::pm_cmd_t cmd_o
);
    // each command is valid only without its partner bit
    always_comb begin
        cmd_o.arm_idle = wr_data_i[IDLE_ARM] & ~wr_data_i[IDLE_GO];
        cmd_o.go_idle  = wr_data_i[IDLE_GO]  & ~wr_data_i[IDLE_ARM];
        cmd_o.arm_pd   = wr_data_i[PD_ARM]   & ~wr_data_i[PD_GO];
        cmd_o.go_pd    = wr_data_i[PD_GO]    & ~wr_data_i[PD_ARM];
    end
endmodule

// File: rtl/pmg_rst_qual.sv
module pmg_rst_qual #(
    parameter int RST_MC = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mc_stb_i,
    output logic full_rst_o
);
    localparam int CW = $clog2(RST_MC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RST_MC);

    logic [CW-1:0] cnt_q;
    logic          sat;

    assign sat        = (cnt_q == LIMIT);
    assign full_rst_o = rst_i & sat;

    always_ff @(posedge clk_i) begin
        if (!rst_i)
            cnt_q <= '0;
        else if (mc_stb_i && !sat)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pmg_ctl_store.sv
module pmg_ctl_store #(
    parameter int DW        = 8,
    parameter int IDLE_ARM  = 0,
    parameter int IDLE_GO   = 5,
    parameter int PD_ARM    = 1,
    parameter int PD_GO     = 6
) (
    input  logic          clk_i,
    input  logic          full_rst_i,
    input  logic          wr_ok_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o
);
    localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] CMD_MASK = (ONE << IDLE_ARM) | (ONE << IDLE_GO)
                                       | (ONE << PD_ARM)   | (ONE << PD_GO);

    logic [DW-1:0] keep_q;

    // command positions are never stored, so they read back zero
    always_ff @(posedge clk_i) begin
        if (full_rst_i)
            keep_q <= '0;
        else if (wr_ok_i)
            keep_q <= wr_data_i & ~CMD_MASK;
    end

    assign rd_data_o = keep_q;
endmodule

// File: rtl/pmg_fsm.sv
module pmg_fsm (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               mode_lock_i,
    input  logic               irq_pend_i,
    input  logic               wr_en_i,
    input  pmg_pkg::pm_cmd_t   cmd_i,
    output logic               store_en_o,
    output logic               idle_o,
    output logic               pdown_o,
    output logic               hold_o
);
    import pmg_pkg::*;

    pm_state_t state_q, state_d;
    pm_state_t arm_target;

    // a clean arm of exactly one mode selects the armed state
    always_comb begin
        if (cmd_i.arm_idle && !cmd_i.arm_pd)
            arm_target = PM_IDLE_ARMED;
        else if (cmd_i.arm_pd && !cmd_i.arm_idle)
            arm_target = PM_PD_ARMED;
        else
            arm_target = PM_RUN;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (mode_lock_i)
                    state_d = PM_RUN;
                else if (wr_en_i)
                    state_d = arm_target;
            end
            PM_IDLE_ARMED: begin
                if (mode_lock_i)
                    state_d = PM_RUN;
                else if (wr_en_i)
                    state_d = cmd_i.go_idle ? PM_IDLE : arm_target;
            end
            PM_PD_ARMED: begin
                if (mode_lock_i)
                    state_d = PM_RUN;
                else if (wr_en_i)
                    state_d = cmd_i.go_pd ? PM_PDOWN : arm_target;
            end
            PM_IDLE: begin
                if (irq_pend_i)
                    state_d = PM_RUN;
            end
            PM_PDOWN: begin
                state_d = PM_PDOWN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= PM_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        idle_o     = 1'b0;
        pdown_o    = 1'b0;
        hold_o     = 1'b0;
        store_en_o = 1'b0;
        unique case (state_q)
            PM_RUN, PM_IDLE_ARMED, PM_PD_ARMED: store_en_o = wr_en_i & ~rst_i;
            PM_IDLE:  idle_o = 1'b1;
            PM_PDOWN: begin
                pdown_o = 1'b1;
                hold_o  = 1'b1;
            end
            default: store_en_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwr_mode_guard.sv
module pwr_mode_guard #(
    parameter int DW        = 8,
    parameter int IDLE_ARM  = 0,
    parameter int IDLE_GO   = 5,
    parameter int PD_ARM    = 1,
    parameter int PD_GO     = 6,
    parameter int RST_MC    = 2
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          mc_stb_i,
    input  logic          mode_lock_i,
    input  logic          irq_pend_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          idle_o,
    output logic          pdown_o,
    output logic          clkout_hold_o,
    output logic          ale_hold_o,
    output logic          psen_hold_o
);
    pmg_pkg::pm_cmd_t cmd;
    logic             full_rst;
    logic             store_en;
    logic             hold;

    pmg_cmd_decode #(
        .DW(DW), .IDLE_ARM(IDLE_ARM), .IDLE_GO(IDLE_GO),
        .PD_ARM(PD_ARM), .PD_GO(PD_GO)
    ) u_dec (
        .wr_data_i (wr_data_i),
        .cmd_o     (cmd)
    );

    pmg_rst_qual #(.RST_MC(RST_MC)) u_rq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mc_stb_i   (mc_stb_i),
        .full_rst_o (full_rst)
    );

    pmg_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mode_lock_i (mode_lock_i),
        .irq_pend_i  (irq_pend_i),
        .wr_en_i     (wr_en_i),
        .cmd_i       (cmd),
        .store_en_o  (store_en),
        .idle_o      (idle_o),
        .pdown_o     (pdown_o),
        .hold_o      (hold)
    );

    pmg_ctl_store #(
        .DW(DW), .IDLE_ARM(IDLE_ARM), .IDLE_GO(IDLE_GO),
        .PD_ARM(PD_ARM), .PD_GO(PD_GO)
    ) u_store (
        .clk_i      (clk_i),
        .full_rst_i (full_rst),
        .wr_ok_i    (store_en),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o)
    );

    assign clkout_hold_o = hold;
    assign ale_hold_o    = hold;
    assign psen_hold_o   = hold;
endmodule

// File: rtl/pwr_mode_guard_chk.sv
module pwr_mode_guard_chk #(
    parameter int DW        = 8,
    parameter int IDLE_ARM  = 0,
    parameter int IDLE_GO   = 5,
    parameter int PD_ARM    = 1,
    parameter int PD_GO     = 6
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          mode_lock_i,
    input logic          irq_pend_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wr_data_i,
    input logic [DW-1:0] rd_data_o,
    input logic          idle_o,
    input logic          pdown_o,
    input logic          clkout_hold_o,
    input logic          ale_hold_o,
    input logic          psen_hold_o
);
    bit seen_rst = 1'b0;
    always_ff @(posedge clk_i) if (rst_i) seen_rst <= 1'b1;

    assert_lock_blocks_R1: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        (mode_lock_i && !idle_o && !pdown_o) |=> (!idle_o && !pdown_o));

    assert_idle_entry_R2: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        $rose(idle_o) |-> $past(wr_en_i && wr_data_i[IDLE_GO] && !wr_data_i[IDLE_ARM] && !mode_lock_i));

    assert_pd_entry_R2: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        $rose(pdown_o) |-> $past(wr_en_i && wr_data_i[PD_GO] && !wr_data_i[PD_ARM] && !mode_lock_i));

    assert_both_bits_R4: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        (!idle_o && !pdown_o && wr_en_i && wr_data_i[IDLE_ARM] && wr_data_i[IDLE_GO]
         && !wr_data_i[PD_GO]) |=> !idle_o);

    assert_cmd_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        !rd_data_o[IDLE_ARM] && !rd_data_o[IDLE_GO] && !rd_data_o[PD_ARM] && !rd_data_o[PD_GO]);

    assert_irq_wakes_R7: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        (idle_o && irq_pend_i) |=> !idle_o);

    assert_pd_sticky_R8: assert property (@(posedge clk_i) disable iff (!seen_rst || rst_i)
        pdown_o |=> pdown_o);

    assert_holds_R8: assert property (@(posedge clk_i) disable iff (!seen_rst)
        (clkout_hold_o == pdown_o) && (ale_hold_o == pdown_o) && (psen_hold_o == pdown_o));

    assert_rst_clears_R9: assert property (@(posedge clk_i) disable iff (!seen_rst)
        rst_i |=> (!idle_o && !pdown_o));
endmodule

bind pwr_mode_guard pwr_mode_guard_chk #(
    .DW(DW), .IDLE_ARM(IDLE_ARM), .IDLE_GO(IDLE_GO), .PD_ARM(PD_ARM), .PD_GO(PD_GO)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .mode_lock_i   (mode_lock_i),
    .irq_pend_i    (irq_pend_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .idle_o        (idle_o),
    .pdown_o       (pdown_o),
    .clkout_hold_o (clkout_hold_o),
    .ale_hold_o    (ale_hold_o),
    .psen_hold_o   (psen_hold_o)
);

// File: tb/pwr_mode_guard_test.sv
module pwr_mode_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KEEP = 8'h9C;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst, stb, lock, irq, we;
    logic [7:0] wd, rd;
    logic       idle, pd, h_clk, h_ale, h_psen;

    pwr_mode_guard uut (
        .clk_i(clk), .rst_i(rst), .mc_stb_i(stb), .mode_lock_i(lock),
        .irq_pend_i(irq), .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd),
        .idle_o(idle), .pdown_o(pd), .clkout_hold_o(h_clk),
        .ale_hold_o(h_ale), .psen_hold_o(h_psen)
    );

    int total = 0;
    int bad   = 0;
    int m_st  = 0;   // 0 run, 1 idle armed, 2 pd armed, 3 idle, 4 pdown
    int m_cnt = 0;
    logic [7:0] m_store = 8'h00;

    function automatic int arm_of(input logic [7:0] d);
        logic ai, ap;
        ai = d[0] & ~d[5];
        ap = d[1] & ~d[6];
        if (ai && !ap) return 1;
        if (ap && !ai) return 2;
        return 0;
    endfunction

    function automatic int next_st(input int s, input logic w, input logic [7:0] d,
                                   input logic lk, input logic ir, input logic rs);
        if (rs) return 0;
        case (s)
            0, 1, 2: begin
                if (lk) return 0;
                if (!w) return s;
                if (s == 1 && d[5] && !d[0]) return 3;
                if (s == 2 && d[6] && !d[1]) return 4;
                return arm_of(d);
            end
            3: return ir ? 0 : 3;
            default: return 4;
        endcase
    endfunction

    task automatic check(input string tag);
        logic ei, ep;
        ei = (m_st == 3);
        ep = (m_st == 4);
        total++;
        if (idle !== ei || pd !== ep || h_clk !== ep || h_ale !== ep ||
            h_psen !== ep || rd !== m_store) begin
            bad++;
            $display("FAIL %s: got idle=%b pd=%b holds=%b%b%b rd=%h, expected idle=%b pd=%b holds=%b rd=%h",
                     tag, idle, pd, h_clk, h_ale, h_psen, rd, ei, ep, ep, m_store);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] d, input logic lk,
                       input logic ir, input logic rs, input logic sb, input string tag);
        logic full;
        we = w; wd = d; lock = lk; irq = ir; rst = rs; stb = sb;
        full = rs && (m_cnt >= 2);
        if (full) m_store = 8'h00;
        else if (w && !rs && m_st <= 2) m_store = d & KEEP;
        m_cnt = !rs ? 0 : ((sb && m_cnt < 2) ? m_cnt + 1 : m_cnt);
        m_st  = next_st(m_st, w, d, lk, ir, rs);
        @(negedge clk);
        if (tag != "") check(tag);
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        we = 0; wd = 0; lock = 0; irq = 0; rst = 0; stb = 0;
        @(negedge clk);
        cyc(0, 8'h00, 0, 0, 1, 1, "");
        cyc(0, 8'h00, 0, 0, 1, 1, "");
        cyc(0, 8'h00, 0, 0, 1, 0, "R9 reset state");
        cyc(0, 8'h00, 0, 0, 0, 0, "R9 after reset");

        // R6 storage and zero command bits
        wr(8'hFF, "R6 command bits read zero");
        wr(8'h9C, "R6 storage bits");
        // R1 lock blocks entry
        cyc(1, 8'h01, 1, 0, 0, 0, "R1 arm with lock high");
        wr(8'h20, "R1 start after locked arm");
        wr(8'h01, "R1 arm");
        cyc(1, 8'h20, 1, 0, 0, 0, "R1 start with lock high");
        // R2 idle entry and R7 wake
        wr(8'h01, "R2 idle arm");
        wr(8'h20, "R2 idle entered");
        wr(8'h84, "R7 write ignored in idle");
        cyc(0, 8'h00, 0, 1, 0, 0, "R7 interrupt wakes");
        // R4 both bits in one write
        wr(8'h21, "R4 both idle bits");
        wr(8'h20, "R4 start after both");
        wr(8'h03, "R4 both arm bits");
        wr(8'h20, "R4 start after double arm");
        // R3 reversed order
        wr(8'h20, "R3 start first");
        wr(8'h01, "R3 arm second");
        wr(8'h20, "R3 start after later arm");
        cyc(0, 8'h00, 0, 1, 0, 0, "R7 wake again");
        // R5 intervening writes
        wr(8'h01, "R5 arm");
        wr(8'h04, "R5 unrelated write");
        wr(8'h20, "R5 start after disarm");
        wr(8'h01, "R5 arm");
        wr(8'h01, "R5 re-arm");
        wr(8'h20, "R5 start after re-arm");
        cyc(0, 8'h00, 0, 1, 0, 0, "R7 wake");
        // R8 power-down
        wr(8'h02, "R8 pd arm");
        wr(8'h40, "R8 pd entered");
        cyc(0, 8'h00, 0, 1, 0, 0, "R8 interrupt ignored");
        wr(8'hFF, "R8 write ignored in pd");
        // R9 short reset keeps storage, long reset clears it
        cyc(0, 8'h00, 0, 0, 1, 0, "R9 short reset leaves pd");
        cyc(0, 8'h00, 0, 0, 0, 0, "R9 storage kept");
        wr(8'h01, "R9 arm");
        wr(8'h20, "R9 idle");
        cyc(0, 8'h00, 0, 0, 1, 1, "R9 reset exits idle");
        cyc(0, 8'h00, 0, 0, 1, 1, "R9 reset held");
        cyc(0, 8'h00, 0, 0, 1, 0, "R9 full reset clears storage");
        cyc(0, 8'h00, 0, 0, 0, 0, "R9 released");

        // constrained random
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1: d = 8'h01;
                2, 3: d = 8'h20;
                4:    d = 8'h02;
                5:    d = 8'h40;
                6:    d = 8'h21;
                default: d = 8'($urandom);
            endcase
            cyc(1'($urandom_range(0, 1)), d, ($urandom_range(0, 7) == 0),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 39) == 0),
                1'($urandom_range(0, 1)), "R2 R5 R7 R8 random model");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule